// File: doc/BRIEF.md
# Self-Timed Serial EEPROM Program Sequencer

This block is the programming engine behind a serial EEPROM command front-end. The front-end shifts in an instruction and, once it is fully received, strobes this block with a decoded opcode, a word address and a data word. The block holds the write-enable latch and arms a program operation when an erase or write request arrives with the latch set. It then runs a self-timed programming cycle, starting when chip select goes low. The cycle updates either one addressed word or every word of the array through a one-word-per-clock array write port.

While the cycle runs, and after it ends, the block drives a ready/busy level toward the serial data-out pad. The pad is enabled only when chip select has been high for a configurable number of clocks and a status indication is pending. The indication is dismissed by an SK rising edge taken with both chip select and the data input high, which is the start bit of the next instruction. The cycle length is a parameter in system clocks. Chip select, SK and DIN arrive already synchronized to the system clock.

Top module: `eeprom_prog_seq`

## Requirements
- R1: After reset the write-enable latch is clear. An accepted strobe with `cmd_op`=1 sets it and one with `cmd_op`=2 clears it. `cmd_op`=0 (read) leaves it unchanged.
- R2: While the latch is clear, program strobes are ignored and leave the array untouched. These are `cmd_op`=3 (write word), 4 (erase word), 5 (write all) and 6 (erase all).
- R3: A programming cycle starts only on the chip-select falling edge that follows an accepted program strobe. A chip-select fall with no such strobe starts nothing and writes nothing.
- R4: A write-word cycle stores `cmd_data` at `cmd_addr` and touches no other word. An erase-word cycle stores all ones there. Each issues exactly one array write.
- R5: A write-all cycle writes `cmd_data` to every one of the 2^ADDR_W words. An erase-all cycle writes all ones to every word. Each issues exactly one array write per word.
- R6: From the clock after the starting chip-select fall, `dout_val` is 0 until the cycle ends and 1 afterwards.
- R7: `dout_oe` is 0 after reset and whenever chip select is low. It goes to 1 only once chip select has been high for STATUS_DLY clocks while a status indication is pending.
- R8: With chip select high, an SK rising edge while DIN is 1 clears the pending indication and drops `dout_oe`. An SK rising edge with DIN 0 does not.
- R9: A programming cycle lasts exactly PROG_CYCLES clocks. Strobes of any opcode that arrive during it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release upstream |
| cmd_valid | input | 1 | One-clock strobe: a complete instruction has been decoded |
| cmd_op | input | 3 | Decoded opcode (0 read, 1 enable, 2 disable, 3 write, 4 erase, 5 write all, 6 erase all) |
| cmd_addr | input | ADDR_W | Word address of the instruction |
| cmd_data | input | DATA_W | Data word of the instruction |
| cs | input | 1 | Synchronized chip select level |
| sk | input | 1 | Synchronized serial clock level |
| din | input | 1 | Synchronized serial data input level |
| arr_we | output | 1 | Array write enable, one word per clock |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| dout_val | output | 1 | Ready/busy level for the data-out pad (1 ready) |
| dout_oe | output | 1 | Data-out pad enable for the status level |

## Verification
Every cycle, the checker confirms several properties. The pad enable never rises with chip select low. The latch only sets after an enable strobe. Each cycle begins on the clock after a chip-select fall. Array writes occur only inside a cycle, and each cycle spans exactly PROG_CYCLES clocks. Only the bench's scenarios can show the effect on data. These scenarios cover the stored contents after single-word and whole-array operations across a sweep of addresses and patterns, and the refusal of program requests with the latch clear or during a cycle. They also cover the absence of any write after an incomplete instruction, and the exact clock on which the status pad becomes enabled and is dismissed.

// File: rtl/eeprom_prog_pkg.sv
package eeprom_prog_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WEN   = 3'd1,
    OP_WDS   = 3'd2,
    OP_WORD  = 3'd3,
    OP_CLRW  = 3'd4,
    OP_FILL  = 3'd5,
    OP_CLRA  = 3'd6
  } prog_op_e;

endpackage

// File: rtl/ps_edge_detect.sv
module ps_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  output logic cs_fall,
  output logic sk_rise
);

  logic cs_q;
  logic sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
    end
  end

  assign cs_fall = cs_q & ~cs;
  assign sk_rise = sk & ~sk_q;

endmodule

// File: rtl/ps_cycle_timer.sv
module ps_cycle_timer #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_all,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);

  localparam int WORDS = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] NWORD = CNT_W'(WORDS);

  logic              busy_q, busy_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              all_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              load;

  assign load = start & ~busy_q;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (load) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_n = 1'b0;
      else               cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      all_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_n;
      if (load || busy_q) cnt_q <= cnt_n;
      if (load) begin
        all_q  <= start_all;
        addr_q <= start_addr;
        data_q <= start_data;
      end
    end
  end

  assign busy      = busy_q;
  assign arr_we    = busy_q & (all_q ? (cnt_q < NWORD) : (cnt_q == '0));
  assign arr_addr  = all_q ? cnt_q[ADDR_W-1:0] : addr_q;
  assign arr_wdata = data_q;

endmodule

// File: rtl/ps_status_out.sv
module ps_status_out #(
  parameter int STATUS_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic din,
  input  logic sk_rise,
  input  logic start,
  input  logic busy,
  output logic dout_val,
  output logic dout_oe
);

  localparam int DW = (STATUS_DLY < 1) ? 1 : $clog2(STATUS_DLY + 1);
  localparam logic [DW-1:0] HOLD = DW'(STATUS_DLY);

  logic          flag_q, flag_n;
  logic [DW-1:0] hold_q, hold_n;

  always_comb begin
    flag_n = flag_q;
    if (start)                     flag_n = 1'b1;
    else if (cs && din && sk_rise) flag_n = 1'b0;
  end

  always_comb begin
    hold_n = hold_q;
    if (!cs)                hold_n = '0;
    else if (hold_q != HOLD) hold_n = hold_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      hold_q <= '0;
    end else begin
      flag_q <= flag_n;
      hold_q <= hold_n;
    end
  end

  assign dout_val = ~busy;
  assign dout_oe  = cs & flag_q & (hold_q == HOLD);

endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq
  import eeprom_prog_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 400,
  parameter int STATUS_DLY  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cs,
  input  logic              sk,
  input  logic              din,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic              dout_val,
  output logic              dout_oe
);

  logic              cs_fall, sk_rise, busy, start;
  logic              accept, is_prog, pend_load;
  logic              wel_q, wel_n;
  logic              pend_q, pend_n;
  logic              pall_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] pdata_q;
  prog_op_e          op;

  assign op      = prog_op_e'(cmd_op);
  assign accept  = cmd_valid & ~busy;
  assign is_prog = (op == OP_WORD) || (op == OP_CLRW) ||
                   (op == OP_FILL) || (op == OP_CLRA);
  assign pend_load = accept & is_prog & wel_q & ~cs_fall;
  assign start     = cs_fall & pend_q & ~busy;

  ps_edge_detect u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .sk      (sk),
    .cs_fall (cs_fall),
    .sk_rise (sk_rise)
  );

  always_comb begin
    wel_n = wel_q;
    if (accept && op == OP_WEN) wel_n = 1'b1;
    if (accept && op == OP_WDS) wel_n = 1'b0;
  end

  always_comb begin
    pend_n = pend_q;
    if (cs_fall)        pend_n = 1'b0;
    else if (pend_load) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q   <= 1'b0;
      pend_q  <= 1'b0;
      pall_q  <= 1'b0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      wel_q  <= wel_n;
      pend_q <= pend_n;
      if (pend_load) begin
        pall_q  <= (op == OP_FILL) || (op == OP_CLRA);
        paddr_q <= cmd_addr;
        pdata_q <= ((op == OP_CLRW) || (op == OP_CLRA)) ? '1 : cmd_data;
      end
    end
  end

  ps_cycle_timer #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_all  (pall_q),
    .start_addr (paddr_q),
    .start_data (pdata_q),
    .busy       (busy),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .arr_wdata  (arr_wdata)
  );

  ps_status_out #(
    .STATUS_DLY (STATUS_DLY)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .din      (din),
    .sk_rise  (sk_rise),
    .start    (start),
    .busy     (busy),
    .dout_val (dout_val),
    .dout_oe  (dout_oe)
  );

endmodule

// File: rtl/eeprom_prog_seq_chk.sv
module eeprom_prog_seq_chk #(
  parameter int PROG_CYCLES = 400
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       wel,
  input logic       busy,
  input logic       dout_oe,
  input logic       arr_we
);

  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  p_oe_needs_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> cs);

  p_wel_set_by_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> ($past(cmd_valid) && $past(cmd_op) == 3'd1));

  p_start_on_cs_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(cs) && $past(cs, 2)));

  p_write_inside_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  p_cycle_length_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == PROG_CYCLES));

endmodule

bind eeprom_prog_seq eeprom_prog_seq_chk #(
  .PROG_CYCLES (PROG_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs        (cs),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .wel       (wel_q),
  .busy      (busy),
  .dout_oe   (dout_oe),
  .arr_we    (arr_we)
);

// File: tb/eeprom_prog_seq_tb.sv
module eeprom_prog_seq_tb;

  localparam int AW = 7;
  localparam int DW = 16;
  localparam int PC = 300;
  localparam int SD = 4;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          cs, sk, din;
  logic          arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic          dout_val, dout_oe;

  logic [DW-1:0] mem_obs [WORDS];
  logic [DW-1:0] mem_exp [WORDS];
  int            wr_cnt = 0;
  int            n_chk = 0;
  int            n_bad = 0;
  logic          wel_exp = 1'b0;

  always #10 clk = ~clk;

  eeprom_prog_seq #(
    .ADDR_W (AW), .DATA_W (DW), .PROG_CYCLES (PC), .STATUS_DLY (SD)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
    .cmd_addr (cmd_addr), .cmd_data (cmd_data), .cs (cs), .sk (sk), .din (din),
    .arr_we (arr_we), .arr_addr (arr_addr), .arr_wdata (arr_wdata),
    .dout_val (dout_val), .dout_oe (dout_oe)
  );

  always @(posedge clk) begin
    if (arr_we) begin
      mem_obs[arr_addr] <= arr_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmp_mem(input string req);
    int diff = 0;
    for (int i = 0; i < WORDS; i++) if (mem_obs[i] !== mem_exp[i]) diff++;
    chk(req, diff, 0);
  endtask

  function automatic void model(input logic [2:0] op, input logic [AW-1:0] a,
                                input logic [DW-1:0] d);
    case (op)
      3'd1: wel_exp = 1'b1;
      3'd2: wel_exp = 1'b0;
      3'd3: if (wel_exp) mem_exp[a] = d;
      3'd4: if (wel_exp) mem_exp[a] = '1;
      3'd5: if (wel_exp) for (int i = 0; i < WORDS; i++) mem_exp[i] = d;
      3'd6: if (wel_exp) for (int i = 0; i < WORDS; i++) mem_exp[i] = '1;
      default: ;
    endcase
  endfunction

  // strobe one instruction with CS high, then drop CS
  task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); cs = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    @(negedge clk); cs = 1'b0;
    model(op, a, d);
  endtask

  task automatic wait_prog();
    repeat (PC + 5) @(negedge clk);
  endtask

  task automatic prog_op(input string req, input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input int exp_writes);
    int w0 = wr_cnt;
    send(op, a, d);
    wait_prog();
    chk(req, wr_cnt - w0, exp_writes);
    cmp_mem(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w0;
    int zeros;
    for (int i = 0; i < WORDS; i++) begin mem_obs[i] = '0; mem_exp[i] = '0; end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
    cs = 1'b0; sk = 1'b0; din = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 reset oe", dout_oe, 0);
    chk("R4 reset we", arr_we, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R2: latch clear after reset, program requests refused
    prog_op("R2 write refused", 3'd3, 7'd3, 16'h1234, 0);
    prog_op("R2 fill refused", 3'd5, 7'd0, 16'h5555, 0);

    send(3'd1, '0, '0); repeat (3) @(negedge clk);

    // R6/R7/R8/R9: status on a single-word write
    w0 = wr_cnt;
    send(3'd3, 7'd10, 16'hBEEF);
    @(negedge clk); cs = 1'b1;
    chk("R7 oe before hold", dout_oe, 0);
    chk("R6 busy level", dout_val, 0);
    zeros = 0;
    for (int i = 0; i < 2000; i++) begin
      if (dout_val === 1'b1) break;
      zeros++;
      if (i == SD - 1) chk("R7 oe one clock early", dout_oe, 0);
      if (i == SD)     chk("R7 oe after hold", dout_oe, 1);
      if (i == 20) begin cmd_op = 3'd2; cmd_valid = 1'b1; end
      if (i == 21) cmd_valid = 1'b0;
      if (i == 22) begin cmd_op = 3'd3; cmd_addr = 7'd9; cmd_data = 16'h0BAD; cmd_valid = 1'b1; end
      if (i == 23) cmd_valid = 1'b0;
      @(negedge clk);
    end
    chk("R9 cycle length", zeros, PC);
    chk("R6 ready level", dout_val, 1);
    chk("R6 ready enabled", dout_oe, 1);
    @(negedge clk); sk = 1'b1;
    @(negedge clk); sk = 1'b0;
    chk("R8 din low keeps status", dout_oe, 1);
    @(negedge clk); din = 1'b1; sk = 1'b1;
    @(negedge clk); sk = 1'b0; din = 1'b0;
    chk("R8 status dismissed", dout_oe, 0);
    @(negedge clk); cs = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 busy strobes ignored", wr_cnt - w0, 1);
    cmp_mem("R4 word written, R9 late write dropped");

    // R4 sweep: writes and erases across the address range
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] a;
      a = AW'((k * 37) % WORDS);
      if (k == 7) a = AW'(WORDS - 1);
      prog_op("R4 write sweep", 3'd3, a, DW'(a) * 16'h0101 ^ 16'hA5C3, 1);
    end
    prog_op("R4 erase word", 3'd4, 7'd0, 16'h0000, 1);
    prog_op("R4 erase top word", 3'd4, 7'd127, 16'h0000, 1);
    prog_op("R9 latch kept after busy disable", 3'd3, 7'd9, 16'h7E57, 1);

    // R5: whole-array operations
    prog_op("R5 fill", 3'd5, 7'd44, 16'h3C5A, WORDS);
    prog_op("R5 erase all", 3'd6, 7'd0, 16'h0000, WORDS);
    prog_op("R5 fill again", 3'd5, 7'd0, 16'h00F0, WORDS);

    // R3: incomplete instruction, CS falls without a strobe
    w0 = wr_cnt;
    @(negedge clk); cs = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sk = ~sk; din = i[0];
    end
    @(negedge clk); sk = 1'b0; din = 1'b0; cs = 1'b0;
    wait_prog();
    chk("R3 no strobe no write", wr_cnt - w0, 0);
    cmp_mem("R3 array unchanged");

    // R1: read strobe keeps latch, disable clears it, enable restores it
    send(3'd0, 7'd1, '0); repeat (3) @(negedge clk);
    prog_op("R1 read keeps latch", 3'd3, 7'd1, 16'hC0DE, 1);
    send(3'd2, '0, '0); repeat (3) @(negedge clk);
    prog_op("R1 disabled write", 3'd3, 7'd2, 16'hDEAD, 0);
    prog_op("R2 disabled erase all", 3'd6, 7'd0, 16'h0000, 0);
    send(3'd1, '0, '0); repeat (3) @(negedge clk);
    prog_op("R1 re-enabled write", 3'd3, 7'd2, 16'h4321, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule